// File: doc/BRIEF.md
# Predicated Execute Unit with Operand Shifter

This block is the execute stage of a small register machine. Each cycle it takes one decoded operation with two register values and produces the ALU result, a register write strobe and a branch decision. A stored relation state (greater, equal, less) is written only by compare operations. Every operation carries a 3-bit condition code that is tested against that stored state. An operation whose condition fails is dropped: it writes no register and leaves the relation state alone.

The second operand first passes through a barrel shifter that takes an immediate shift amount. A shift followed by an add, subtract, move or compare therefore completes as one operation. A branch request uses the same condition logic and reports whether the branch is taken. Fetch and the register file sit outside the block. The result and the strobes are combinational. The relation state is registered and takes its new value at the clock edge after a compare executes.

Top module: `cond_alu_exec`

## Requirements
- R1: While reset is asserted and after it is released, `rel_flags` {gt,eq,lt} reads 3'b010 (equal) until a compare executes.
- R2: An executed compare (`op`=2'b11, `br_req`=0) compares `src_a` with the shifted second operand as signed values. From the next clock edge `rel_flags` holds exactly one bit set: 3'b100 if greater, 3'b010 if equal, 3'b001 if less.
- R3: Condition codes, tested against the current `rel_flags`: 000 always, 001 eq, 010 not eq, 011 gt, 100 lt, 101 gt or eq, 110 lt or eq.
- R4: An operation whose condition fails has no effect. `wr_en` stays 0, `br_taken` stays 0 and `rel_flags` is unchanged at the next edge.
- R5: `wr_en` is 1 exactly when `valid`, `wr_req`, a passing condition, `br_req`=0 and `op` is not compare all hold.
- R6: `result` is `src_a` + B for `op`=2'b00, `src_a` − B for 2'b01 and B for 2'b10, where B is the shifted second operand, all modulo 2^32.
- R7: The shifter is selected by `shf_kind`. 00 is a logical left shift, 01 a logical right shift, 10 an arithmetic right shift, and 11 passes `src_b` unchanged. A `shf_amt` of 0 passes `src_b` unchanged for every kind.
- R8: `br_taken` is 1 exactly when `valid`, `br_req` and a passing condition all hold. A branch request never raises `wr_en` and never changes `rel_flags`.
- R9: Only an executed compare changes `rel_flags`. The conditions of an operation are tested against the state held before that operation's own edge.
- R10: Condition code 111 never passes, so neither `wr_en` nor `br_taken` rises and no compare executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Operation present this cycle |
| op | input | 2 | 00 add, 01 sub, 10 mov, 11 compare |
| cond | input | 3 | Condition code |
| br_req | input | 1 | Operation is a conditional branch |
| wr_req | input | 1 | Operation intends a register write |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand before shifting |
| shf_kind | input | 2 | Shift kind |
| shf_amt | input | 5 | Immediate shift amount |
| result | output | 32 | ALU result |
| wr_en | output | 1 | Register write strobe |
| br_taken | output | 1 | Branch resolves taken |
| rel_flags | output | 3 | Stored relation {gt,eq,lt} |

## Verification
A compare can carry a condition that reads the relation state the same compare is about to overwrite. Likewise, a conditional subtract or branch can follow on the very next cycle and read the freshly written state. The bench provokes the first case directly: it sets the state to greater, then issues a compare that is conditioned on less, and checks that the state stays put. Random streams with small operand values produce many compare-then-conditional pairs. Each pair is judged against a bench model that updates its relation copy only at the clock edge after a compare executes.

// File: rtl/cae_pkg.sv
package cae_pkg;
  typedef enum logic [1:0] {OP_ADD = 2'b00, OP_SUB = 2'b01, OP_MOV = 2'b10, OP_CMP = 2'b11} op_e;
  typedef enum logic [1:0] {SH_LSL = 2'b00, SH_LSR = 2'b01, SH_ASR = 2'b10, SH_NONE = 2'b11} shf_e;
  typedef enum logic [2:0] {
    CC_AL = 3'd0, CC_EQ = 3'd1, CC_NE = 3'd2, CC_GT = 3'd3,
    CC_LT = 3'd4, CC_GE = 3'd5, CC_LE = 3'd6, CC_NV = 3'd7
  } cc_e;
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;
endpackage

// File: rtl/cae_shifter.sv
module cae_shifter
  import cae_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [AW+1];

  assign stg[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] shl, shr, sha;
    assign shl = stg[k] << S;
    assign shr = stg[k] >> S;
    assign sha = $signed(stg[k]) >>> S;
    assign stg[k+1] = !amt[k]               ? stg[k] :
                      (kind == SH_LSL)      ? shl    :
                      (kind == SH_ASR)      ? sha    : shr;
  end

  assign dout = (kind == SH_NONE) ? din : stg[AW];
endmodule

// File: rtl/cae_cond.sv
module cae_cond
  import cae_pkg::*;
(
  input  rel_t       rel,
  input  logic [2:0] cc,
  output logic       pass
);
  always_comb begin
    unique case (cc_e'(cc))
      CC_AL:   pass = 1'b1;
      CC_EQ:   pass = rel.eq;
      CC_NE:   pass = !rel.eq;
      CC_GT:   pass = rel.gt;
      CC_LT:   pass = rel.lt;
      CC_GE:   pass = rel.gt | rel.eq;
      CC_LE:   pass = rel.lt | rel.eq;
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/cae_alu.sv
module cae_alu
  import cae_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output rel_t         rel
);
  always_comb begin
    unique case (op_e'(op))
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MOV:  y = b;
      default: y = a - b;
    endcase
  end

  always_comb begin
    rel.gt = $signed(a) > $signed(b);
    rel.lt = $signed(a) < $signed(b);
    rel.eq = (a == b);
  end
endmodule

// File: rtl/cae_flags.sv
module cae_flags
  import cae_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd_en,
  input  rel_t rel_in,
  output rel_t rel_q
);
  rel_t rel_nxt;

  always_comb begin
    rel_nxt = rel_q;
    if (upd_en) rel_nxt = rel_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
    else        rel_q <= rel_nxt;
  end
endmodule

// File: rtl/cond_alu_exec.sv
module cond_alu_exec
  import cae_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SHW    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [1:0]        op,
  input  logic [2:0]        cond,
  input  logic              br_req,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [1:0]        shf_kind,
  input  logic [SHW-1:0]    shf_amt,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              br_taken,
  output logic [2:0]        rel_flags
);
  logic [DATA_W-1:0] opnd_b;
  rel_t              rel_q, rel_cmp;
  logic              cc_pass, go, is_cmp, flag_upd;

  cae_shifter #(.W(DATA_W), .AW(SHW)) u_shf (
    .din(src_b), .kind(shf_kind), .amt(shf_amt), .dout(opnd_b)
  );

  cae_cond u_cond (.rel(rel_q), .cc(cond), .pass(cc_pass));

  cae_alu #(.W(DATA_W)) u_alu (
    .op(op), .a(src_a), .b(opnd_b), .y(result), .rel(rel_cmp)
  );

  assign go       = valid && cc_pass;
  assign is_cmp   = (op_e'(op) == OP_CMP);
  assign flag_upd = go && !br_req && is_cmp;

  cae_flags u_flags (
    .clk(clk), .rst_n(rst_n), .upd_en(flag_upd), .rel_in(rel_cmp), .rel_q(rel_q)
  );

  assign wr_en     = go && !br_req && wr_req && !is_cmp;
  assign br_taken  = go && br_req;
  assign rel_flags = rel_q;
endmodule

// File: rtl/cae_checker.sv
module cae_checker #(
  parameter int DATA_W = 32,
  parameter int SHW    = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic [1:0]        op,
  input logic [2:0]        cond,
  input logic              br_req,
  input logic              wr_req,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [SHW-1:0]    shf_amt,
  input logic              wr_en,
  input logic              br_taken,
  input logic [2:0]        rel_flags
);
  // R2
  rel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rel_flags) == 1);

  // R2
  cmp_greater_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !br_req && op == 2'b11 && cond == 3'b000 && shf_amt == '0 &&
     $signed(src_a) > $signed(src_b)) |=> (rel_flags == 3'b100));

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && !br_req && op == 2'b11) |=> $stable(rel_flags));

  // R4
  failed_gt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cond == 3'b011 && !rel_flags[2]) |=> $stable(rel_flags));

  // R5
  wr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (valid && wr_req && !br_req && op != 2'b11));

  // R8
  br_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (valid && br_req && !wr_en));

  // R10
  never_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 3'b111) |-> (!wr_en && !br_taken));
endmodule

bind cond_alu_exec cae_checker #(.DATA_W(DATA_W), .SHW(SHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .cond(cond),
  .br_req(br_req), .wr_req(wr_req), .src_a(src_a), .src_b(src_b),
  .shf_amt(shf_amt), .wr_en(wr_en), .br_taken(br_taken), .rel_flags(rel_flags)
);

// File: tb/cond_alu_exec_bench.sv
module cond_alu_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid, br_req, wr_req;
  logic [1:0]  op, shf_kind;
  logic [2:0]  cond;
  logic [31:0] src_a, src_b;
  logic [4:0]  shf_amt;
  logic [31:0] result;
  logic        wr_en, br_taken;
  logic [2:0]  rel_flags;

  int total = 0;
  int bad   = 0;
  logic [2:0] m_rel;

  always #5 clk = ~clk;

  cond_alu_exec u_cond_alu_exec (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .cond(cond),
    .br_req(br_req), .wr_req(wr_req), .src_a(src_a), .src_b(src_b),
    .shf_kind(shf_kind), .shf_amt(shf_amt), .result(result),
    .wr_en(wr_en), .br_taken(br_taken), .rel_flags(rel_flags)
  );

  function automatic logic [31:0] f_shift(logic [31:0] b, logic [1:0] k, logic [4:0] s);
    case (k)
      2'b00:   return b << s;
      2'b01:   return b >> s;
      2'b10:   return $signed(b) >>> s;
      default: return b;
    endcase
  endfunction

  function automatic logic f_cond(logic [2:0] c, logic [2:0] r);
    case (c)
      3'd0: return 1'b1;
      3'd1: return r[1];
      3'd2: return !r[1];
      3'd3: return r[2];
      3'd4: return r[0];
      3'd5: return r[2] | r[1];
      3'd6: return r[0] | r[1];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] f_rel(logic [31:0] a, logic [31:0] b);
    if ($signed(a) > $signed(b)) return 3'b100;
    if (a == b) return 3'b010;
    return 3'b001;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] o, input logic [2:0] c,
                      input logic br, input logic wi, input logic [31:0] a,
                      input logic [31:0] b, input logic [1:0] k, input logic [4:0] s);
    logic [31:0] bs, exp_y;
    logic pass, exp_wr, exp_br, exp_upd;
    @(negedge clk);
    valid = v; op = o; cond = c; br_req = br; wr_req = wi;
    src_a = a; src_b = b; shf_kind = k; shf_amt = s;
    #1;
    bs      = f_shift(b, k, s);
    pass    = v && f_cond(c, m_rel);
    exp_wr  = pass && !br && wi && (o != 2'b11);
    exp_br  = pass && br;
    exp_upd = pass && !br && (o == 2'b11);
    case (o)
      2'b00:   exp_y = a + bs;
      2'b01:   exp_y = a - bs;
      default: exp_y = bs;
    endcase
    chk(wr_en == exp_wr, (c == 3'd7) ? "R10 wr_en" : "R5 wr_en", 32'(wr_en), 32'(exp_wr));
    chk(br_taken == exp_br, (c == 3'd7) ? "R10 br_taken" : "R8 br_taken", 32'(br_taken), 32'(exp_br));
    if (o != 2'b11) chk(result == exp_y, "R6/R7 result", result, exp_y);
    @(posedge clk);
    if (exp_upd) m_rel = f_rel(a, bs);
    #1;
    chk(rel_flags == m_rel, exp_upd ? "R2 compare flags" : "R9 flags held", 32'(rel_flags), 32'(m_rel));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; valid = 0; op = 0; cond = 0; br_req = 0; wr_req = 0;
    src_a = 0; src_b = 0; shf_kind = 0; shf_amt = 0;
    m_rel = 3'b010;
    #23;
    chk(rel_flags == 3'b010, "R1 reset flags", 32'(rel_flags), 32'h2);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rel_flags == 3'b010, "R1 flags after release", 32'(rel_flags), 32'h2);

    // R7 amount 0 passes, LSL by 2 folded into add, ASR fill, pass kind
    step(1, 2'b10, 3'd0, 0, 1, 32'h0, 32'hDEADBEEF, 2'b00, 5'd0);
    step(1, 2'b00, 3'd0, 0, 1, 32'd10, 32'd3, 2'b00, 5'd2);
    step(1, 2'b10, 3'd0, 0, 1, 32'h0, 32'h80000000, 2'b10, 5'd31);
    step(1, 2'b10, 3'd0, 0, 1, 32'h0, 32'h80000000, 2'b01, 5'd31);
    step(1, 2'b10, 3'd0, 0, 1, 32'h0, 32'h12345678, 2'b11, 5'd9);
    // R2 signed extremes
    step(1, 2'b11, 3'd0, 0, 0, 32'h7FFFFFFF, 32'h80000000, 2'b00, 5'd0);
    // R3 sub under gt passes, under lt fails
    step(1, 2'b01, 3'd3, 0, 1, 32'd9, 32'd4, 2'b00, 5'd0);
    step(1, 2'b01, 3'd4, 0, 1, 32'd9, 32'd4, 2'b00, 5'd0);
    // R4 / R9 compare conditioned on lt while gt is stored: no change
    step(1, 2'b11, 3'd4, 0, 0, 32'd1, 32'd1, 2'b00, 5'd0);
    // R8 branch ne while gt, then equalize and retry
    step(1, 2'b00, 3'd2, 1, 1, 32'd1, 32'd1, 2'b00, 5'd0);
    step(1, 2'b11, 3'd0, 0, 0, 32'd5, 32'd5, 2'b00, 5'd0);
    step(1, 2'b00, 3'd2, 1, 1, 32'd1, 32'd1, 2'b00, 5'd0);
    // R10 never
    step(1, 2'b11, 3'd7, 0, 1, 32'd1, 32'd2, 2'b00, 5'd0);
    step(1, 2'b00, 3'd7, 1, 1, 32'd1, 32'd2, 2'b00, 5'd0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      r = $urandom;
      a = r[28] ? 32'($urandom % 4) - 32'd2 : $urandom;
      b = r[29] ? 32'($urandom % 4) - 32'd2 : $urandom;
      step(r[3:0] != 0, r[5:4], r[8:6], r[11:9] == 0, r[12], a, b,
           r[14:13], r[27] ? 5'd0 : r[19:15]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule